// File: doc/BRIEF.md
# Companion Chip System Control Register Bank

This block is the byte-wide control register bank of a peripheral companion chip. A host reaches it through an 8-bit offset with separate write and read strobes. The bank merges eight internal sub-interrupt lines into one host interrupt. Each line has a status bit that follows its level, and a mask register gates the status bits.

The bank also drives a 24-bit general-purpose output port. The port has a data register and an output-enable register, each split into three byte lanes. A pin's effective level is its data bit ANDed with its enable bit. Whenever that level changes, downstream logic gets a one-cycle event on the pin together with the new level. A further eight bytes of clock and PLL settings are held as plain storage and have no other effect.

Top module: `sys_ctl_regs`

## Requirements
- R1: A read strobe at offset 0x08 returns 0x03 and at offset 0x09 returns 0x00, on `rdData` in the cycle after the strobe. `rdData` holds its value until the next read strobe.
- R2: The interrupt status byte at 0x50 and the interrupt mask byte at 0x52 can be written and read back.
- R3: When sub-interrupt line n changes level, status bit n takes the new level at the next clock edge.
- R4: `hostIrq` is high exactly when the bitwise AND of status and mask is nonzero.
- R5: The output data register occupies 0x78..0x7A and the output-enable register occupies 0x7C..0x7E. The lowest address holds pin bits 7..0 and the highest holds pin bits 23..16.
- R6: `gpioLevel` shows data AND enable for every pin, one cycle after the write that changed it.
- R7: `gpioChg` pulses for exactly one cycle, with one bit per pin whose effective level changed, in the same cycle as the new `gpioLevel`. A write that changes no effective level produces no pulse.
- R8: A write to one byte lane of a multi-byte register changes only that lane.
- R9: Offsets 0x98..0x9F are eight read/write storage bytes with no other effect.
- R10: Reads of unmapped offsets (for example 0x51, 0x7B, 0x7F) return 0. Writes to unmapped offsets change no register and no output.
- R11: After reset, status, mask, output data, output enable and the previous effective level are all zero, and `hostIrq` is low.
- R12: A direct write to the status byte replaces it. A later level change on line n then sets or clears bit n again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Byte write strobe |
| rdStb | input | 1 | Byte read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| subIrq | input | 8 | Sub-interrupt levels (0 NAND, 1 card, 2 USB host, 3 serial, 4 display) |
| rdData | output | 8 | Read data, valid the cycle after `rdStb` |
| hostIrq | output | 1 | Combined host interrupt |
| gpioLevel | output | 24 | Effective output level per pin |
| gpioChg | output | 24 | One-cycle change event per pin |

## Verification
The bench sets an enable lane while the matching data is zero. This catches a design that reports raw data instead of data AND enable, because such a design would emit a spurious event there. It writes one data lane and then reads back its neighbours, which exposes a lane write that clobbers the whole word. It also checks that the event lasts exactly one cycle, which fails if the previous level is never updated.

On the interrupt side, the bench overwrites status while a line is held high and then toggles other lines. A design that re-sampled every line on every cycle would wipe out the written bits. Unmapped reads and writes placed next to real registers catch offset decodes that are off by one.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  parameter int GP_LANES    = 3;
  parameter int STORE_BYTES = 8;
  parameter int SUB_LINES   = 8;
  localparam int GP_W  = GP_LANES * 8;
  localparam int IDX_W = $clog2(STORE_BYTES);
  localparam int SLOTS = 1 << IDX_W;

  localparam logic [7:0] OFF_REV   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h50;
  localparam logic [7:0] OFF_MASK  = 8'h52;
  localparam logic [7:0] OFF_GPDAT = 8'h78;
  localparam logic [7:0] OFF_GPOE  = 8'h7C;
  localparam logic [7:0] OFF_STORE = 8'h98;
  localparam logic [7:0] REV_LO    = 8'h03;

  typedef enum logic [2:0] {
    RD_ZERO, RD_REV, RD_STAT, RD_MASK, RD_DAT, RD_OE, RD_STORE
  } rdSel_e;

  typedef struct packed {
    logic                   wrStat;
    logic                   wrMask;
    logic [GP_LANES-1:0]    wrDat;
    logic [GP_LANES-1:0]    wrOe;
    logic [STORE_BYTES-1:0] wrStore;
    logic                   rdEn;
    rdSel_e                 rdSel;
    logic [IDX_W-1:0]       idx;
  } strb_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic [7:0] addr,
  output strb_t      strb
);
  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    strb.rdEn  = rdStb;
    if (addr == OFF_REV) begin
      strb.rdSel = RD_REV;
    end else if (addr == OFF_STAT) begin
      strb.rdSel  = RD_STAT;
      strb.wrStat = wrStb;
    end else if (addr == OFF_MASK) begin
      strb.rdSel  = RD_MASK;
      strb.wrMask = wrStb;
    end
    for (int i = 0; i < GP_LANES; i++) begin
      if (addr == OFF_GPDAT + 8'(i)) begin
        strb.rdSel    = RD_DAT;
        strb.idx      = IDX_W'(i);
        strb.wrDat[i] = wrStb;
      end
      if (addr == OFF_GPOE + 8'(i)) begin
        strb.rdSel   = RD_OE;
        strb.idx     = IDX_W'(i);
        strb.wrOe[i] = wrStb;
      end
    end
    for (int i = 0; i < STORE_BYTES; i++) begin
      if (addr == OFF_STORE + 8'(i)) begin
        strb.rdSel      = RD_STORE;
        strb.idx        = IDX_W'(i);
        strb.wrStore[i] = wrStb;
      end
    end
  end

  // R10 guard: an offset outside every window must raise no write strobe
  logic mapped;
  always_comb begin
    mapped = (addr == OFF_STAT) || (addr == OFF_MASK) ||
             (addr >= OFF_GPDAT && addr < OFF_GPDAT + 8'(GP_LANES)) ||
             (addr >= OFF_GPOE  && addr < OFF_GPOE  + 8'(GP_LANES)) ||
             (addr >= OFF_STORE && addr < OFF_STORE + 8'(STORE_BYTES));
    if (!mapped)
      a_r10_unmapped_no_write: assert (!strb.wrStat && !strb.wrMask &&
        strb.wrDat == '0 && strb.wrOe == '0 && strb.wrStore == '0);
  end
endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strb_t                strb,
  input  logic [7:0]           wdata,
  input  logic [SUB_LINES-1:0] subIrq,
  output logic [7:0]           rdData,
  output logic                 hostIrq,
  output logic [GP_W-1:0]      gpioLevel,
  output logic [GP_W-1:0]      gpioChg
);
  logic [SUB_LINES-1:0] statusR, maskR, subPrev, subDiff, statBase;
  logic [GP_W-1:0]      datR, oeR, levelR, chgR, eff;
  logic [7:0]           storeR [STORE_BYTES];
  logic [7:0]           datLane [SLOTS];
  logic [7:0]           oeLane  [SLOTS];
  logic [7:0]           rdVal, rdR;

  // interrupt status: a level change on a line wins over a direct write
  assign subDiff  = subIrq ^ subPrev;
  assign statBase = strb.wrStat ? wdata[SUB_LINES-1:0] : statusR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusR <= '0;
      maskR   <= '0;
      subPrev <= '0;
    end else begin
      subPrev <= subIrq;
      statusR <= (statBase & ~subDiff) | (subIrq & subDiff);
      if (strb.wrMask) maskR <= wdata[SUB_LINES-1:0];
    end
  end

  assign hostIrq = |(statusR & maskR);

  // output port lanes
  for (genvar g = 0; g < GP_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        datR[g*8 +: 8] <= '0;
        oeR[g*8 +: 8]  <= '0;
      end else begin
        if (strb.wrDat[g]) datR[g*8 +: 8] <= wdata;
        if (strb.wrOe[g])  oeR[g*8 +: 8]  <= wdata;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (g < GP_LANES) begin : gUsed
      assign datLane[g] = datR[g*8 +: 8];
      assign oeLane[g]  = oeR[g*8 +: 8];
    end else begin : gPad
      assign datLane[g] = '0;
      assign oeLane[g]  = '0;
    end
  end

  assign eff = datR & oeR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelR <= '0;
      chgR   <= '0;
    end else begin
      levelR <= eff;
      chgR   <= eff ^ levelR;
    end
  end

  assign gpioLevel = levelR;
  assign gpioChg   = chgR;

  // clock / PLL storage
  for (genvar g = 0; g < STORE_BYTES; g++) begin : gStore
    always_ff @(posedge clk) begin
      if (!rstN)               storeR[g] <= '0;
      else if (strb.wrStore[g]) storeR[g] <= wdata;
    end
  end

  // read path
  always_comb begin
    rdVal = '0;
    case (strb.rdSel)
      RD_REV:   rdVal = (strb.idx == '0) ? REV_LO : 8'h00;
      RD_STAT:  rdVal = 8'(statusR);
      RD_MASK:  rdVal = 8'(maskR);
      RD_DAT:   rdVal = datLane[strb.idx];
      RD_OE:    rdVal = oeLane[strb.idx];
      RD_STORE: rdVal = storeR[strb.idx];
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdR <= '0;
    else if (strb.rdEn) rdR <= rdVal;
  end
  assign rdData = rdR;

  // assertions
  for (genvar g = 0; g < SUB_LINES; g++) begin : gStatChk
    a_r3_status_follows: assert property (@(posedge clk) disable iff (!rstN)
      (subIrq[g] != subPrev[g]) |=> (statusR[g] == $past(subIrq[g])));
  end

  a_r4_masked_rise_irq: assert property (@(posedge clk) disable iff (!rstN)
    ((|(subIrq & ~subPrev & maskR)) && !strb.wrMask) |=> hostIrq);

  for (genvar g = 0; g < GP_LANES; g++) begin : gLaneChk
    a_r8_lane_kept: assert property (@(posedge clk) disable iff (!rstN)
      !strb.wrDat[g] |=> $stable(datR[g*8 +: 8]));
  end

  a_r7_no_write_no_event: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDat == '0 && strb.wrOe == '0) |=> ##1 (gpioChg == '0));
endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import sysctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStb,
  input  logic                 rdStb,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic [SUB_LINES-1:0] subIrq,
  output logic [7:0]           rdData,
  output logic                 hostIrq,
  output logic [GP_W-1:0]      gpioLevel,
  output logic [GP_W-1:0]      gpioChg
);
  strb_t strb;

  sysctl_ctrl i_ctrl (
    .wrStb (wrStb),
    .rdStb (rdStb),
    .addr  (addr),
    .strb  (strb)
  );

  sysctl_dpath i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (wdata),
    .subIrq    (subIrq),
    .rdData    (rdData),
    .hostIrq   (hostIrq),
    .gpioLevel (gpioLevel),
    .gpioChg   (gpioChg)
  );
endmodule

// File: tb/test_sys_ctl_regs.sv
module test_sys_ctl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, subIrq = '0;
  logic [7:0]  rdData;
  logic        hostIrq;
  logic [23:0] gpioLevel, gpioChg;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  sys_ctl_regs i_sys_ctl_regs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .addr(addr),
    .wdata(wdata), .subIrq(subIrq), .rdData(rdData), .hostIrq(hostIrq),
    .gpioLevel(gpioLevel), .gpioChg(gpioChg)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrStb = 1'b1;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0; d = rdData;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic setSub(input logic [7:0] v);
    @(negedge clk); subIrq = v;
    @(negedge clk);
  endtask

  task automatic testReset;
    rdChk("R11 status", 8'h50, 8'h00);
    rdChk("R11 mask", 8'h52, 8'h00);
    chk("R11 gpioLevel", 32'(gpioLevel), 0);
    chk("R11 hostIrq", 32'(hostIrq), 0);
  endtask

  task automatic testRevision;
    rdChk("R1 rev lo", 8'h08, 8'h03);
    rdChk("R1 rev hi", 8'h09, 8'h00);
    @(negedge clk);
    chk("R1 hold", 32'(rdData), 0);
  endtask

  task automatic testIrq;
    wr(8'h52, 8'h01);
    rdChk("R2 mask rb", 8'h52, 8'h01);
    setSub(8'h04);
    chk("R4 masked line", 32'(hostIrq), 0);
    rdChk("R3 status", 8'h50, 8'h04);
    setSub(8'h05);
    chk("R4 unmasked line", 32'(hostIrq), 1);
    setSub(8'h04);
    chk("R4 line drop", 32'(hostIrq), 0);
  endtask

  task automatic testOverwrite;
    wr(8'h50, 8'hF0);
    rdChk("R12 overwrite", 8'h50, 8'hF0);
    wr(8'h52, 8'h10);
    @(negedge clk);
    chk("R4 written bit", 32'(hostIrq), 1);
    setSub(8'h00);
    rdChk("R12 other bits kept", 8'h50, 8'hF0);
    setSub(8'h10);
    setSub(8'h00);
    rdChk("R12 line reclears", 8'h50, 8'hE0);
    chk("R4 after reclear", 32'(hostIrq), 0);
  endtask

  task automatic testGpio;
    wr(8'h7C, 8'hFF);
    @(negedge clk);
    chk("R7 enable only", 32'(gpioChg), 0);
    chk("R6 enable only", 32'(gpioLevel), 0);
    wr(8'h78, 8'h0F);
    @(negedge clk);
    chk("R7 event", 32'(gpioChg), 32'h00000F);
    chk("R6 level", 32'(gpioLevel), 32'h00000F);
    @(negedge clk);
    chk("R7 one cycle", 32'(gpioChg), 0);
    wr(8'h7A, 8'hA5);
    @(negedge clk);
    chk("R7 disabled lane", 32'(gpioChg), 0);
    rdChk("R5 data lane2", 8'h7A, 8'hA5);
    rdChk("R8 data lane0 kept", 8'h78, 8'h0F);
    rdChk("R8 data lane1 kept", 8'h79, 8'h00);
    wr(8'h7E, 8'h81);
    @(negedge clk);
    chk("R7 lane2 event", 32'(gpioChg), 32'h810000);
    chk("R6 lane2 level", 32'(gpioLevel), 32'h81000F);
    wr(8'h7C, 8'h00);
    @(negedge clk);
    chk("R7 disable event", 32'(gpioChg), 32'h00000F);
    chk("R6 disable level", 32'(gpioLevel), 32'h810000);
    rdChk("R5 oe lane2", 8'h7E, 8'h81);
  endtask

  task automatic testStore;
    for (int i = 0; i < 8; i++) wr(8'h98 + 8'(i), 8'h11 * 8'(i + 1));
    for (int i = 0; i < 8; i++) rdChk("R9 storage", 8'h98 + 8'(i), 8'h11 * 8'(i + 1));
    wr(8'h9A, 8'h5A);
    rdChk("R8 store lane", 8'h9A, 8'h5A);
    rdChk("R8 store neighbour", 8'h9B, 8'h44);
  endtask

  task automatic testUnmapped;
    wr(8'h7B, 8'hFF);
    wr(8'h7F, 8'hFF);
    wr(8'h51, 8'hFF);
    @(negedge clk);
    chk("R10 no event", 32'(gpioChg), 0);
    chk("R10 level kept", 32'(gpioLevel), 32'h810000);
    rdChk("R10 read 7B", 8'h7B, 8'h00);
    rdChk("R10 read 7F", 8'h7F, 8'h00);
    rdChk("R10 read 51", 8'h51, 8'h00);
    rdChk("R10 status kept", 8'h50, 8'hE0);
    rdChk("R10 mask kept", 8'h52, 8'h10);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2000000;
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRevision();
    testIrq();
    testOverwrite();
    testGpio();
    testStore();
    testUnmapped();
    summary();
  end
endmodule